// File: doc/BRIEF.md
# Pulse-Width Serial Request Transmitter

This block sends a fixed command byte to a game controller over one bidirectional data line. The line has no clock beside it. Each bit is a self-timed cell of four equal sub-intervals. A one holds the line low for the first sub-interval and high for the other three. A zero holds it low for three sub-intervals and high for the last one. With a 4 MHz clock and four clock cycles per sub-interval, every cell lasts 16 cycles, or 4 µs.

A one-cycle start strobe begins a frame. The frame is the 8-bit command, most significant bit first, followed at once by a stop cell coded as a one. There is no gap between cells. The block drives a pad value and an active-low output enable for an external tri-state buffer. Outside a frame the enable is deasserted, so the line is released and floats high. A one-cycle done pulse marks the end of the frame. It appears in the same cycle that the line is released.

Top module: `req_pulse_tx`

## Requirements
- R1: A synchronous active-low reset returns the block to idle. In the cycle after the first clock edge with `rst_n` low, and in every cycle after that until `rst_n` rises, `line_oe_n`=1, `line_drv`=1 and `done`=0. This holds even when reset arrives in the middle of a frame.
- R2: While idle with no start strobe, `line_oe_n` stays 1 and `line_drv` stays 1.
- R3: A clock edge that samples `start`=1 while the block is idle begins a frame. In the next cycle `line_oe_n`=0 and `line_drv`=0.
- R4: A cell lasts 16 cycles. A one-cell drives 0 for 4 cycles and then 1 for 12 cycles. A zero-cell drives 0 for 12 cycles and then 1 for 4 cycles. The low part always comes first.
- R5: The data cells carry the default command 0x01 most significant bit first. Cells 0 to 6 are zero-cells and cell 7 is a one-cell. Cell k occupies cycles 16k+1 to 16k+16 after the accepting edge.
- R6: Cell 8 (cycles 129 to 144) is a stop cell coded as a one.
- R7: The cells follow each other with no idle time. `line_oe_n` is 0 for exactly 144 consecutive cycles in each frame.
- R8: `done` is 1 for exactly one cycle, cycle 145. In that same cycle `line_oe_n` returns to 1. `done` is never 1 at any other time.
- R9: A start strobe sampled while a frame is in progress is ignored, including one sampled at the edge that ends cycle 144. The waveform and the done timing are unchanged, and no second frame follows.
- R10: A start strobe sampled at the edge ending the done cycle (cycle 145) is accepted. A new frame begins in cycle 146.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame start strobe, sampled on the rising edge |
| line_drv | output | 1 | Value for the pad buffer data input; 1 while idle |
| line_oe_n | output | 1 | Pad buffer enable, active low (0 drives the pad) |
| done | output | 1 | One-cycle pulse in the cycle the line is released |

## Verification
Every result is measured from the rising edge that samples the strobe: the line goes low one register stage later, in cycle 1. Cell k then occupies cycles 16k+1 to 16k+16, and the release and the done pulse are both due in cycle 145. The bench changes inputs and samples outputs only on falling edges. This gives each recorded value a cycle number counted from that accepting edge. Each value is compared with the expected level for that cycle number, which the bench computes from the cell rules. Strobes that should be ignored or accepted are placed at given cycle numbers: cycle 40, cycle 144 and cycle 145.

// File: rtl/req_tx_pkg.sv
`timescale 1ns/1ps
// Package req_tx_pkg
// Shared types for the pulse-width request transmitter.
// Assumes nothing beyond a single clock domain.
package req_tx_pkg;

    // Pad control pair handed from the cell encoder to the top level.
    typedef struct packed {
        logic oe_n;   // active-low buffer enable
        logic drv;    // value presented to the buffer
    } pad_drive_t;

    // Total driven cycles in one frame.
    function automatic int unsigned frame_cycles(int unsigned cells,
                                                 int unsigned subs,
                                                 int unsigned cyc);
        return cells * subs * cyc;
    endfunction

endpackage

// File: rtl/req_tx_timer.sv
`timescale 1ns/1ps
// Module req_tx_timer
// Divides the clock into sub-intervals and sub-intervals into cells.
// It reports the current sub-interval index and a strobe on the last
// cycle of each cell. Assumes clear and run are never both needed at once;
// clear has priority.
module req_tx_timer #(
    parameter int SUB_CYCLES   = 4,
    parameter int SUBS_PER_BIT = 4,
    localparam int CW = (SUB_CYCLES   > 1) ? $clog2(SUB_CYCLES)   : 1,
    localparam int PW = (SUBS_PER_BIT > 1) ? $clog2(SUBS_PER_BIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [PW-1:0] phase,
    output logic          cell_end
);

    localparam logic [CW-1:0] SUB_LAST = CW'(SUB_CYCLES - 1);
    localparam logic [PW-1:0] PH_LAST  = PW'(SUBS_PER_BIT - 1);

    logic [CW-1:0] sub_cnt;
    logic          sub_end;

    assign sub_end  = (sub_cnt == SUB_LAST);
    assign cell_end = run && sub_end && (phase == PH_LAST);

    // Advance the cycle and sub-interval counters while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sub_cnt <= '0;
            phase   <= '0;
        end else if (run) begin
            if (sub_end) begin
                sub_cnt <= '0;
                phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/req_tx_shifter.sv
`timescale 1ns/1ps
// Module req_tx_shifter
// Holds the frame (command byte followed by a stop bit of 1) and presents
// the bit of the current cell, most significant first. It flags the last
// (stop) cell. Assumes advance pulses once per cell.
module req_tx_shifter #(
    parameter int                   DATA_BITS = 8,
    parameter logic [DATA_BITS-1:0] CMD       = 8'h01,
    localparam int FW = DATA_BITS + 1,
    localparam int IW = $clog2(FW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic cur_bit,
    output logic last_cell
);

    logic [FW-1:0] frame;
    logic [IW-1:0] cell_idx;

    assign cur_bit   = frame[FW-1];
    assign last_cell = (cell_idx == IW'(DATA_BITS));

    // Load the frame on start and shift one bit out per completed cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame    <= '1;
            cell_idx <= '0;
        end else if (load) begin
            frame    <= {CMD, 1'b1};
            cell_idx <= '0;
        end else if (advance) begin
            frame    <= {frame[FW-2:0], 1'b1};
            cell_idx <= cell_idx + 1'b1;
        end
    end

endmodule

// File: rtl/req_tx_encoder.sv
`timescale 1ns/1ps
// Module req_tx_encoder
// Maps the bit value and the sub-interval index to the pad drive. The line
// is low for the leading ONE_LOW or ZERO_LOW sub-intervals and high for the
// rest. It is released whenever no frame is active. Purely combinational.
module req_tx_encoder
    import req_tx_pkg::*;
#(
    parameter int SUBS_PER_BIT = 4,
    parameter int ONE_LOW      = 1,
    parameter int ZERO_LOW     = 3,
    localparam int PW = (SUBS_PER_BIT > 1) ? $clog2(SUBS_PER_BIT) : 1
) (
    input  logic          active,
    input  logic [PW-1:0] phase,
    input  logic          bit_val,
    output pad_drive_t    drive
);

    logic [31:0] low_len;

    // Choose the low length for the bit and compare with the phase.
    always_comb begin
        low_len    = bit_val ? 32'(ONE_LOW) : 32'(ZERO_LOW);
        drive.oe_n = !active;
        drive.drv  = !active || (32'(phase) >= low_len);
    end

endmodule

// File: rtl/req_pulse_tx.sv
`timescale 1ns/1ps
// Module req_pulse_tx
// Top level of the request transmitter. A start strobe while idle sends the
// command frame as back-to-back pulse-width cells. It then releases the
// line and pulses done. Strobes during a frame are dropped.
// Assumes start is synchronous to clk; the pad buffer is external.
module req_pulse_tx
    import req_tx_pkg::*;
#(
    parameter int                   SUB_CYCLES    = 4,
    parameter int                   SUBS_PER_BIT  = 4,
    parameter int                   DATA_BITS     = 8,
    parameter logic [DATA_BITS-1:0] CMD_BYTE      = 8'h01,
    parameter int                   ONE_LOW_SUBS  = 1,
    parameter int                   ZERO_LOW_SUBS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic line_drv,
    output logic line_oe_n,
    output logic done
);

    localparam int PW = (SUBS_PER_BIT > 1) ? $clog2(SUBS_PER_BIT) : 1;

    logic          active;
    logic          load;
    logic          cell_end;
    logic          cur_bit;
    logic          last_cell;
    logic          frame_end;
    logic [PW-1:0] phase;
    pad_drive_t    drive;

    assign load      = start && !active;
    assign frame_end = cell_end && last_cell;

    // Track the frame in progress and raise done as the line is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= active && frame_end;
            if (load) begin
                active <= 1'b1;
            end else if (frame_end) begin
                active <= 1'b0;
            end
        end
    end

    req_tx_timer #(
        .SUB_CYCLES   (SUB_CYCLES),
        .SUBS_PER_BIT (SUBS_PER_BIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .run      (active),
        .phase    (phase),
        .cell_end (cell_end)
    );

    req_tx_shifter #(
        .DATA_BITS (DATA_BITS),
        .CMD       (CMD_BYTE)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (cell_end),
        .cur_bit   (cur_bit),
        .last_cell (last_cell)
    );

    req_tx_encoder #(
        .SUBS_PER_BIT (SUBS_PER_BIT),
        .ONE_LOW      (ONE_LOW_SUBS),
        .ZERO_LOW     (ZERO_LOW_SUBS)
    ) u_encoder (
        .active  (active),
        .phase   (phase),
        .bit_val (cur_bit),
        .drive   (drive)
    );

    assign line_drv  = drive.drv;
    assign line_oe_n = drive.oe_n;

endmodule

// File: rtl/req_pulse_tx_chk.sv
`timescale 1ns/1ps
// Module req_pulse_tx_chk
// Port-level protocol checker for req_pulse_tx. It counts driven cycles and
// low run lengths to check frame length and pulse widths.
module req_pulse_tx_chk #(
    parameter int FRAME_CYCLES = 144,
    parameter int MAX_LOW      = 12
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic line_drv,
    input logic line_oe_n,
    input logic done
);

    logic [15:0] drive_cnt;
    logic [15:0] low_cnt;

    // Count consecutive driven cycles and consecutive driven-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_cnt <= '0;
            low_cnt   <= '0;
        end else begin
            drive_cnt <= line_oe_n ? '0 : drive_cnt + 1'b1;
            low_cnt   <= (line_oe_n || line_drv) ? '0 : low_cnt + 1'b1;
        end
    end

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_n |-> line_drv);

    assert_start_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_n && start) |=> (!line_oe_n && !line_drv));

    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_oe_n && !line_drv) |-> (low_cnt < 16'(MAX_LOW)));

    assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe_n) |-> (drive_cnt == 16'(FRAME_CYCLES)));

    assert_done_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe_n) |-> done);

    assert_release_has_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(line_oe_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind req_pulse_tx req_pulse_tx_chk #(
    .FRAME_CYCLES ((DATA_BITS + 1) * SUBS_PER_BIT * SUB_CYCLES),
    .MAX_LOW      (ZERO_LOW_SUBS * SUB_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .line_drv  (line_drv),
    .line_oe_n (line_oe_n),
    .done      (done)
);

// File: tb/req_pulse_tx_tb.sv
`timescale 1ns/1ps
// Bench for req_pulse_tx. Cycle n counts from the edge that accepts start
// (cycle 1 is the first driven cycle). Outputs are packed as
// {line_oe_n, line_drv, done}.
module req_pulse_tx_tb;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic line_drv;
    logic line_oe_n;
    logic done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [2:0] obs [0:159];

    typedef struct packed {
        logic [7:0] n;
        logic [2:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1,   3'b000}, '{8'd12,  3'b000}, '{8'd13,  3'b010},
        '{8'd16,  3'b010}, '{8'd17,  3'b000}, '{8'd112, 3'b010},
        '{8'd113, 3'b000}, '{8'd116, 3'b000}, '{8'd117, 3'b010},
        '{8'd129, 3'b000}, '{8'd132, 3'b000}, '{8'd133, 3'b010},
        '{8'd144, 3'b010}, '{8'd145, 3'b111}, '{8'd146, 3'b110}
    };

    req_pulse_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .line_drv  (line_drv),
        .line_oe_n (line_oe_n),
        .done      (done)
    );

    always #2 clk = ~clk;

    // Expected outputs in cycle n of a frame, from the cell rules.
    function automatic logic [2:0] model(int n);
        int  k;
        int  pos;
        logic b;
        if (n >= 1 && n <= 144) begin
            k   = (n - 1) / 16;
            pos = (n - 1) % 16;
            b   = (k >= 7);
            return {1'b0, (pos >= (b ? 4 : 12)), 1'b0};
        end else if (n == 145) begin
            return 3'b111;
        end
        return 3'b110;
    endfunction

    function automatic string vec_tag(int n);
        if (n >= 145) return "R8";
        if (n >= 129) return "R6";
        if (n >= 113) return "R5";
        return "R4";
    endfunction

    function automatic logic [2:0] now_out();
        return {line_oe_n, line_drv, done};
    endfunction

    task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Strobe start, then record cycles 1..len; optionally strobe again at poke.
    task automatic capture(int len, int poke);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= len; n++) begin
            obs[n] = now_out();
            start  = (n == poke);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    function automatic int frame_mismatch(int first, int last);
        int bad = 0;
        for (int n = first; n <= last; n++) begin
            if (obs[n] !== model(n)) bad++;
        end
        return bad;
    endfunction

    initial begin
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "reset state", now_out(), 3'b110);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle with no strobe stays released high
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (now_out() !== 3'b110) bad++;
            @(negedge clk);
        end
        chk_int("R2", "idle cycles off 110", bad, 0);

        // Vector table over one frame
        capture(150, 0);
        for (int v = 0; v < NVEC; v++) begin
            chk(vec_tag(int'(VECS[v].n)), $sformatf("cycle %0d", VECS[v].n),
                obs[VECS[v].n], VECS[v].exp);
        end
        chk("R3", "first driven cycle", obs[1], 3'b000);
        chk_int("R7", "whole-frame mismatches", frame_mismatch(1, 150), 0);

        // R9: strobe in the middle of a frame is ignored
        repeat (5) @(negedge clk);
        capture(150, 40);
        chk_int("R9", "mid-frame strobe mismatches", frame_mismatch(1, 150), 0);

        // R9: strobe at the edge ending the last driven cycle is ignored
        repeat (5) @(negedge clk);
        capture(150, 144);
        chk_int("R9", "late strobe mismatches", frame_mismatch(1, 150), 0);

        // R10: strobe in the done cycle starts a new frame at cycle 146
        repeat (5) @(negedge clk);
        capture(150, 145);
        chk_int("R10", "first frame mismatches", frame_mismatch(1, 145), 0);
        chk("R10", "restart cycle 146", obs[146], 3'b000);
        bad = 0;
        for (int n = 147; n <= 150; n++) begin
            if (obs[n] !== model(n - 145)) bad++;
        end
        chk_int("R10", "second frame head mismatches", bad, 0);
        repeat (150) @(negedge clk);
        chk("R8", "idle after second frame", now_out(), 3'b110);

        // R1: reset in the middle of a frame
        capture(40, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-frame reset", now_out(), 3'b110);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset release", now_out(), 3'b110);
        capture(150, 0);
        chk_int("R1", "frame after reset mismatches", frame_mismatch(1, 150), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule